// File: doc/BRIEF.md
# Power-Mode and Clock-Gating Controller

This controller keeps track of which power-managed operating mode a small processor core is in. It turns that mode into three outputs: an enable for the CPU clock, an enable for the peripheral clock, and a one-hot choice among three clock sources (primary, secondary, internal oscillator). The block holds its own configuration register with two fields, an idle flag and a 2-bit source field. These two fields together name one of seven modes: deep sleep, three run modes and three idle modes.

Software changes the run source by writing the register while the core is running. It enters idle or sleep by pulsing the sleep strobe; the idle flag picks idle or sleep, and the source field picks which idle variant. An interrupt, a watchdog timeout or a reset always brings the core back to full-power primary run and clears the source field. The oscillators, the glitch-free clock multiplexer, start-up timers and PLL lock are outside this block: it only decides which clocks run and from which source.

Top module: `pm_clock_ctrl`

## Requirements
- R1: In the first cycle after reset the block is in primary run: mode code 1, both enables high, source select 3'b001, and the readback shows idle flag 0 and source field 00.
- R2: In any run mode (codes 1 to 3), the CPU clock enable and the peripheral clock enable are both high.
- R3: In any idle mode (codes 4 to 6), the CPU clock enable is low and the peripheral clock enable is high.
- R4: In sleep (code 0), both enables are low and the source select is 3'b000.
- R5: The source field value 00 means primary, 01 means secondary, and 10 or 11 means internal oscillator. The source select is one-hot with bit 0 = primary, bit 1 = secondary and bit 2 = internal oscillator, and it follows the source of the current run or idle mode.
- R6: A sleep strobe in a run mode while the idle flag is 0 gives sleep (code 0) on the next cycle.
- R7: A sleep strobe in a run mode while the idle flag is 1 gives the idle mode of the current source field on the next cycle (primary 4, secondary 5, internal 6).
- R8: A sleep strobe while in sleep or an idle mode has no effect on the mode.
- R9: An interrupt or a watchdog event gives primary run (code 1) on the next cycle from any mode. It clears the source field to 00, leaves the idle flag unchanged, and discards a register write in the same cycle.
- R10: A wake event in the same cycle as a sleep strobe wins: the next mode is primary run.
- R11: A register write in a run mode moves the block on the next cycle to the run mode of the written source (codes 1, 2, 3). In sleep or idle, a write only updates the readback and the mode is unchanged.
- R12: The mode code is 0 sleep, 1 primary run, 2 secondary run, 3 internal run, 4 primary idle, 5 secondary idle, 6 internal idle.
- R13: Reset overrides every other input in the same cycle. It forces primary run and clears both the idle flag and the source field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; also acts as the reset wake event |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_idle_wr | input | 1 | Idle flag value to write |
| cfg_src_wr | input | 2 | Source field value to write |
| sleep_stb | input | 1 | One-cycle sleep-instruction strobe |
| irq_evt | input | 1 | Interrupt wake event |
| wdt_evt | input | 1 | Watchdog timeout wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_src_sel | output | 3 | One-hot clock source select (bit0 primary, bit1 secondary, bit2 internal) |
| mode_code | output | 3 | Current mode code |
| cfg_idle | output | 1 | Readback of the idle flag |
| cfg_src | output | 2 | Readback of the source field |

## Verification
All outputs are decoded directly from a single mode register, so a wrong mode state shows up on the enables, the source select and the mode code in the very cycle after the edge that stored it. The most telling failures are a wake that does not return to code 1 with the source field cleared, and an idle entry that chooses a source other than the one in the field. Others are a strobe that is wrongly honoured in idle, and a write in sleep that wakes the core. Each of these shows up on the next sample after the stimulus.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int NUM_SRC = 3;
    localparam int SRC_W   = 2;
    localparam int MODE_W  = 3;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef enum logic [MODE_W-1:0] {
        M_SLEEP    = 3'd0,
        M_PRI_RUN  = 3'd1,
        M_SEC_RUN  = 3'd2,
        M_INT_RUN  = 3'd3,
        M_PRI_IDLE = 3'd4,
        M_SEC_IDLE = 3'd5,
        M_INT_IDLE = 3'd6
    } pm_mode_e;

    function automatic logic [IDX_W-1:0] src_index(input logic [SRC_W-1:0] src);
        if (src[1])      return IDX_W'(2);
        else if (src[0]) return IDX_W'(1);
        else             return IDX_W'(0);
    endfunction

    function automatic pm_mode_e run_mode(input logic [SRC_W-1:0] src);
        case (src_index(src))
            IDX_W'(1): return M_SEC_RUN;
            IDX_W'(2): return M_INT_RUN;
            default:   return M_PRI_RUN;
        endcase
    endfunction

    function automatic pm_mode_e idle_mode(input logic [SRC_W-1:0] src);
        case (src_index(src))
            IDX_W'(1): return M_SEC_IDLE;
            IDX_W'(2): return M_INT_IDLE;
            default:   return M_PRI_IDLE;
        endcase
    endfunction

    function automatic logic mode_is_run(input pm_mode_e m);
        return (m == M_PRI_RUN) || (m == M_SEC_RUN) || (m == M_INT_RUN);
    endfunction

    function automatic logic mode_is_idle(input pm_mode_e m);
        return (m == M_PRI_IDLE) || (m == M_SEC_IDLE) || (m == M_INT_IDLE);
    endfunction

    function automatic logic [IDX_W-1:0] mode_src(input pm_mode_e m);
        case (m)
            M_SEC_RUN, M_SEC_IDLE: return IDX_W'(1);
            M_INT_RUN, M_INT_IDLE: return IDX_W'(2);
            default:               return IDX_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wake,
    input  logic             we,
    input  logic             idle_d,
    input  logic [SRC_W-1:0] src_d,
    output logic             idle_q,
    output logic [SRC_W-1:0] src_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b0;
            src_q  <= '0;
        end else if (wake) begin
            src_q  <= '0;
        end else if (we) begin
            idle_q <= idle_d;
            src_q  <= src_d;
        end
    end

    // R13: reset clears both fields
    p_reset_clears_cfg_r13: assert property (@(posedge clk)
        rst |=> (!idle_q && src_q == '0));

    // R9: wake clears source, keeps idle flag
    p_wake_clears_src_r9: assert property (@(posedge clk) disable iff (rst)
        wake |=> (src_q == '0 && idle_q == $past(idle_q)));

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wake,
    input  logic             sleep_stb,
    input  logic             we,
    input  logic [SRC_W-1:0] src_d,
    input  logic             idle_q,
    input  logic [SRC_W-1:0] src_q,
    output pm_mode_e         mode_q
);

    pm_mode_e mode_n;

    always_comb begin
        mode_n = mode_q;
        if (wake) begin
            mode_n = M_PRI_RUN;
        end else if (mode_is_run(mode_q)) begin
            if (sleep_stb)
                mode_n = idle_q ? idle_mode(src_q) : M_SLEEP;
            else if (we)
                mode_n = run_mode(src_d);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= M_PRI_RUN;
        else     mode_q <= mode_n;
    end

    // R13: reset lands in primary run
    p_reset_pri_r13: assert property (@(posedge clk)
        rst |=> (mode_q == M_PRI_RUN));

    // R9 / R10: any wake returns to primary run, strobe or not
    p_wake_pri_r9: assert property (@(posedge clk) disable iff (rst)
        wake |=> (mode_q == M_PRI_RUN));

    // R8: strobe outside run mode leaves the mode alone
    p_strobe_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (sleep_stb && !wake && !mode_is_run(mode_q)) |=> $stable(mode_q));

    // R6: strobe in run with idle flag clear enters sleep
    p_enter_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        (sleep_stb && !wake && !idle_q && mode_is_run(mode_q)) |=> (mode_q == M_SLEEP));

endmodule

// File: rtl/pm_clk_decode.sv
module pm_clk_decode
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  pm_mode_e           mode,
    output logic               cpu_en,
    output logic               per_en,
    output logic [NUM_SRC-1:0] sel
);

    logic             active;
    logic [IDX_W-1:0] idx;

    assign cpu_en = mode_is_run(mode);
    assign active = mode_is_run(mode) || mode_is_idle(mode);
    assign per_en = active;
    assign idx    = mode_src(mode);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
        assign sel[g] = active && (idx == IDX_W'(g));
    end

    // R2: CPU clocked implies peripherals clocked on one source
    p_run_both_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_en |-> (per_en && $countones(sel) == 1));

    // R3: idle codes gate the CPU only
    p_idle_cpu_off_r3: assert property (@(posedge clk) disable iff (rst)
        (mode >= M_PRI_IDLE) |-> (!cpu_en && per_en));

    // R4: sleep is fully dark
    p_sleep_dark_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == M_SLEEP) |-> (!cpu_en && !per_en && sel == '0));

    // R5: never more than one source
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: rtl/pm_clock_ctrl.sv
module pm_clock_ctrl
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_idle_wr,
    input  logic [SRC_W-1:0]   cfg_src_wr,
    input  logic               sleep_stb,
    input  logic               irq_evt,
    input  logic               wdt_evt,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic [NUM_SRC-1:0] clk_src_sel,
    output logic [MODE_W-1:0]  mode_code,
    output logic               cfg_idle,
    output logic [SRC_W-1:0]   cfg_src
);

    logic     wake;
    pm_mode_e mode_q;

    assign wake = irq_evt || wdt_evt;

    pm_cfg_reg cfg_i (
        .clk    (clk),
        .rst    (rst),
        .wake   (wake),
        .we     (cfg_we),
        .idle_d (cfg_idle_wr),
        .src_d  (cfg_src_wr),
        .idle_q (cfg_idle),
        .src_q  (cfg_src)
    );

    pm_mode_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .wake      (wake),
        .sleep_stb (sleep_stb),
        .we        (cfg_we),
        .src_d     (cfg_src_wr),
        .idle_q    (cfg_idle),
        .src_q     (cfg_src),
        .mode_q    (mode_q)
    );

    pm_clk_decode dec_i (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_q),
        .cpu_en (cpu_clk_en),
        .per_en (per_clk_en),
        .sel    (clk_src_sel)
    );

    assign mode_code = mode_q;

    // R11: a write in sleep or idle must not wake the core
    p_write_no_wake_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !wake && !sleep_stb && !mode_is_run(mode_q)) |=> $stable(mode_code));

endmodule

// File: tb/pm_clock_ctrl_tb_top.sv
module pm_clock_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_idle_wr = 1'b0;
    logic [1:0] cfg_src_wr = 2'b00;
    logic       sleep_stb = 1'b0;
    logic       irq_evt = 1'b0;
    logic       wdt_evt = 1'b0;
    logic       cpu_clk_en, per_clk_en, cfg_idle;
    logic [2:0] clk_src_sel, mode_code;
    logic [1:0] cfg_src;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pm_clock_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_idle_wr (cfg_idle_wr),
        .cfg_src_wr  (cfg_src_wr),
        .sleep_stb   (sleep_stb),
        .irq_evt     (irq_evt),
        .wdt_evt     (wdt_evt),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .clk_src_sel (clk_src_sel),
        .mode_code   (mode_code),
        .cfg_idle    (cfg_idle),
        .cfg_src     (cfg_src)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // expected outputs for a mode code (R2 R3 R4 R5 R12)
    task automatic chk_mode(input string req, input int m);
        int exp_sel;
        chk(req, "mode_code", int'(mode_code), m);
        chk(req, "cpu_clk_en", int'(cpu_clk_en), (m >= 1 && m <= 3) ? 1 : 0);
        chk(req, "per_clk_en", int'(per_clk_en), (m >= 1 && m <= 6) ? 1 : 0);
        case (m)
            1, 4:    exp_sel = 1;
            2, 5:    exp_sel = 2;
            3, 6:    exp_sel = 4;
            default: exp_sel = 0;
        endcase
        chk(req, "clk_src_sel", int'(clk_src_sel), exp_sel);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_in();
        cfg_we = 0; sleep_stb = 0; irq_evt = 0; wdt_evt = 0; rst = 0;
    endtask

    task automatic write_cfg(input logic idle, input logic [1:0] src);
        cfg_we = 1; cfg_idle_wr = idle; cfg_src_wr = src;
        tick(); clear_in();
    endtask

    task automatic strobe();
        sleep_stb = 1; tick(); clear_in();
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick(); clear_in();
        chk_mode("R1", 1);
        chk("R1", "cfg_idle", int'(cfg_idle), 0);
        chk("R1", "cfg_src", int'(cfg_src), 0);
    endtask

    task automatic t_run_switch();
        write_cfg(0, 2'b01); chk_mode("R11", 2); chk_mode("R2", 2);
        write_cfg(0, 2'b10); chk_mode("R5", 3);
        write_cfg(0, 2'b11); chk_mode("R5", 3);
        write_cfg(0, 2'b00); chk_mode("R11", 1);
    endtask

    task automatic t_sleep();
        strobe();            chk_mode("R6", 0); chk_mode("R4", 0);
        strobe();            chk_mode("R8", 0);
        write_cfg(0, 2'b01); chk_mode("R11", 0);
        chk("R11", "cfg_src", int'(cfg_src), 1);
        irq_evt = 1; tick(); clear_in();
        chk_mode("R9", 1);
        chk("R9", "cfg_src", int'(cfg_src), 0);
    endtask

    task automatic t_idle();
        write_cfg(1, 2'b01); chk_mode("R11", 2);
        strobe();            chk_mode("R7", 5); chk_mode("R3", 5);
        strobe();            chk_mode("R8", 5);
        wdt_evt = 1; cfg_we = 1; cfg_idle_wr = 0; cfg_src_wr = 2'b10;
        tick(); clear_in();
        chk_mode("R9", 1);
        chk("R9", "cfg_src", int'(cfg_src), 0);
        chk("R9", "cfg_idle", int'(cfg_idle), 1);
        strobe();            chk_mode("R7", 4);
        irq_evt = 1; tick(); clear_in(); chk_mode("R9", 1);
        write_cfg(1, 2'b11); chk_mode("R5", 3);
        strobe();            chk_mode("R7", 6);
    endtask

    task automatic t_race();
        irq_evt = 1; tick(); clear_in(); chk_mode("R9", 1);
        sleep_stb = 1; irq_evt = 1; tick(); clear_in();
        chk_mode("R10", 1);
        write_cfg(1, 2'b01); strobe(); chk_mode("R7", 5);
        sleep_stb = 1; wdt_evt = 1; tick(); clear_in();
        chk_mode("R10", 1);
        chk("R10", "cfg_src", int'(cfg_src), 0);
    endtask

    task automatic t_reset_prio();
        write_cfg(1, 2'b10); strobe(); chk_mode("R7", 6);
        rst = 1; irq_evt = 1; sleep_stb = 1; cfg_we = 1; cfg_idle_wr = 1; cfg_src_wr = 2'b01;
        tick(); clear_in();
        chk_mode("R13", 1);
        chk("R13", "cfg_idle", int'(cfg_idle), 0);
        chk("R13", "cfg_src", int'(cfg_src), 0);
        strobe(); chk_mode("R6", 0);
    endtask

    initial begin
        tick();
        t_reset();
        t_run_switch();
        t_sleep();
        t_idle();
        t_race();
        t_reset_prio();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule